// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Controller

This block sits beside a serial transceiver and turns its raw status into interrupt and DMA request signals for the rest of the chip. It watches the fill counts of the transmit and receive FIFOs, the programmed watermark levels, the busy state of the transmit shift register and the receiver's error and character strobes. From these it keeps eight per-source flags, produces one registered interrupt line, and produces one DMA request line per direction. Serial shifting, baud timing, FIFO storage and the DMA engine itself belong to other blocks.

The two DMA directions use different comparisons. The transmit request stays up while the transmit FIFO holds fewer entries than its level. The receive request is up only while the receive count equals its level exactly. An idle-gap counter raises a timeout flag when received data sits in the receive FIFO and no new character arrives. Software programs the enable register and clears the sticky flags by writing ones to them.

Every pin is a plain control or status signal, and no port carries a data stream, so there is no valid/ready handshake and no back-pressure. The FIFO counts are treated as levels that are sampled on every clock. The strobes are single-cycle pulses.

Top module: `uart_irq_dma_ctrl`

## Requirements
- R1: After reset, every enable bit, every flag, both DMA requests and the interrupt output are 0.
- R2: Reads are combinational. `rd_addr`=0 returns the enable register in bits 6:0, with bit 7 reading 0. `rd_addr`=1 returns the flag vector, which is also always present on `flag_o`.
- R3: Flag bit 5 (transmit watermark) is 1 when, at the previous clock edge, `tx_count` was strictly less than `tx_level`.
- R4: Flag bit 6 (transmit complete) is 1 when, at the previous edge, `tx_count` was 0 and `tx_shift_busy` was 0.
- R5: Flag bit 7 (receive watermark) is 1 when, at the previous edge, `rx_level` was nonzero and `rx_count` was greater than or equal to `rx_level`.
- R6: `tx_dma_req` is 1 when, at the previous edge, enable bit 5 was set and `tx_count` was less than `tx_level`.
- R7: `rx_dma_req` is 1 when, at the previous edge, enable bit 6 was set and `rx_count` equalled `rx_level`. A count above the level gives no request.
- R8: Flag bits 1 to 4 (overrun, parity, framing, break) are set by a pulse on their error strobe. Once set, each stays set until it is cleared.
- R9: A write with `wr_addr`=1 clears flag bits 0 to 4 wherever `wr_data` holds a 1. A set in the same cycle wins over the clear. Ones written to bits 5 to 7 have no effect.
- R10: `irq` is the registered OR of the flags masked by their enables. Enable bit 0 gates flag 0, bit 1 gates flags 1 to 4, bit 2 gates flag 5, bit 3 gates flag 6 and bit 4 gates flag 7. `irq` changes one cycle after the flags or enables change.
- R11: While `rx_count` is nonzero, an idle counter restarts on `rx_char_stb` or `rx_pop_stb`. Flag bit 0 is set exactly `rx_idle_limit` edges after the last restart, if `rx_count` stays nonzero for that whole time. A limit of 0 disables the timeout, and the counter is held at zero while `rx_count` is 0.
- R12: A write with `wr_addr`=0 loads `wr_data[6:0]` into the enable register. Enable bits 5 and 6 are the transmit and receive DMA enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_count | input | CNT_W | Entries in transmit FIFO |
| tx_level | input | CNT_W | Transmit watermark level |
| tx_shift_busy | input | 1 | Transmit shift register still shifting |
| rx_count | input | CNT_W | Entries in receive FIFO |
| rx_level | input | CNT_W | Receive watermark level |
| rx_char_stb | input | 1 | Pulse: character written into receive FIFO |
| rx_pop_stb | input | 1 | Pulse: receive FIFO read |
| rx_idle_limit | input | TMO_W | Idle timeout in clock cycles, 0 disables |
| err_overrun | input | 1 | Pulse: receive overrun |
| err_parity | input | 1 | Pulse: parity error |
| err_framing | input | 1 | Pulse: framing error |
| err_break | input | 1 | Pulse: break detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = enable register, 1 = flag clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | 0 = enables, 1 = flags |
| rd_data | output | 8 | Read data |
| flag_o | output | 8 | Per-source flags |
| irq | output | 1 | Registered interrupt request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
A wrong comparison in a watermark shows up on a flag or a DMA request one cycle after the count sits at level minus one, at the level, or at level plus one. For this reason the bench holds each of those three counts for at least one cycle. A stuck or miscounted idle counter moves the timeout flag off its exact edge, and a lost sticky bit drops a flag before software has cleared it. The reference model compares every output on every cycle, so any of these faults is reported in the first cycle the outputs diverge. A wrong mask bit appears on `irq` one cycle after the flag.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NFLAG = 8;
  localparam int NEN   = 7;
  localparam int NERR  = 4;

  // flag positions
  localparam int F_IDLE   = 0;
  localparam int F_ERR0   = 1;
  localparam int F_TXWM   = 5;
  localparam int F_TXDONE = 6;
  localparam int F_RXWM   = 7;

  // enable positions
  localparam int E_IDLE   = 0;
  localparam int E_ERR    = 1;
  localparam int E_TXWM   = 2;
  localparam int E_TXDONE = 3;
  localparam int E_RXWM   = 4;
  localparam int E_TXDMA  = 5;
  localparam int E_RXDMA  = 6;

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_FLAGS  = 1'b1
  } uirq_sel_e;
endpackage

// File: rtl/uirq_cfg_reg.sv
module uirq_cfg_reg
  import uirq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           wr_addr,
  input  logic [7:0]     wr_data,
  output logic [NEN-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      en_q <= '0;
    else if (wr_en && (wr_addr == SEL_ENABLE))
      en_q <= wr_data[NEN-1:0];
  end
endmodule

// File: rtl/uirq_level_track.sv
module uirq_level_track #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             txdma_en,
  input  logic             rxdma_en,
  output logic             txwm_q,
  output logic             txdone_q,
  output logic             rxwm_q,
  output logic             tx_req_q,
  output logic             rx_req_q
);
  logic tx_below, rx_reached, rx_exact, tx_empty;

  always_comb begin
    tx_below   = tx_count < tx_level;
    tx_empty   = tx_count == '0;
    rx_reached = (rx_level != '0) && (rx_count >= rx_level);
    rx_exact   = rx_count == rx_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txwm_q   <= 1'b0;
      txdone_q <= 1'b0;
      rxwm_q   <= 1'b0;
      tx_req_q <= 1'b0;
      rx_req_q <= 1'b0;
    end else begin
      txwm_q   <= tx_below;
      txdone_q <= tx_empty && !tx_shift_busy;
      rxwm_q   <= rx_reached;
      tx_req_q <= txdma_en && tx_below;
      rx_req_q <= rxdma_en && rx_exact;
    end
  end
endmodule

// File: rtl/uirq_err_sticky.sv
module uirq_err_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_stb,
  input  logic [N-1:0] clr_stb,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flag_q[i] <= 1'b0;
      else if (set_stb[i])
        flag_q[i] <= 1'b1;
      else if (clr_stb[i])
        flag_q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_rx_idle.sv
module uirq_rx_idle #(
  parameter int CNT_W = 5,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_char_stb,
  input  logic             rx_pop_stb,
  input  logic [TMO_W-1:0] limit,
  input  logic             clr,
  output logic             flag_q
);
  logic [TMO_W-1:0] idle_q;
  logic [TMO_W-1:0] idle_inc;
  logic             restart, running, expire;

  always_comb begin
    restart  = rx_char_stb || rx_pop_stb || (rx_count == '0);
    running  = !restart && (idle_q < limit);
    idle_inc = idle_q + TMO_W'(1);
    expire   = running && (idle_inc == limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idle_q <= '0;
    else if (restart)
      idle_q <= '0;
    else if (running)
      idle_q <= idle_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (expire)
      flag_q <= 1'b1;
    else if (clr)
      flag_q <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_dma_ctrl.sv
module uart_irq_dma_ctrl
  import uirq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] tx_level,
  input  logic             tx_shift_busy,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_level,
  input  logic             rx_char_stb,
  input  logic             rx_pop_stb,
  input  logic [TMO_W-1:0] rx_idle_limit,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             err_break,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             rd_addr,
  output logic [7:0]       rd_data,
  output logic [7:0]       flag_o,
  output logic             irq,
  output logic             tx_dma_req,
  output logic             rx_dma_req
);
  logic [NEN-1:0]   en_q;
  logic [NERR-1:0]  err_stb, err_clr, err_q;
  logic             clr_wr, idle_q;
  logic             txwm_q, txdone_q, rxwm_q;
  logic [NFLAG-1:0] flags, mask;
  logic             irq_q;

  uirq_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_q    (en_q)
  );

  uirq_level_track #(.CNT_W(CNT_W)) u_lvl (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_count      (tx_count),
    .tx_level      (tx_level),
    .tx_shift_busy (tx_shift_busy),
    .rx_count      (rx_count),
    .rx_level      (rx_level),
    .txdma_en      (en_q[E_TXDMA]),
    .rxdma_en      (en_q[E_RXDMA]),
    .txwm_q        (txwm_q),
    .txdone_q      (txdone_q),
    .rxwm_q        (rxwm_q),
    .tx_req_q      (tx_dma_req),
    .rx_req_q      (rx_dma_req)
  );

  always_comb begin
    clr_wr  = wr_en && (wr_addr == SEL_FLAGS);
    err_stb = {err_break, err_framing, err_parity, err_overrun};
    err_clr = clr_wr ? wr_data[F_ERR0 +: NERR] : '0;
  end

  uirq_err_sticky #(.N(NERR)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (err_stb),
    .clr_stb (err_clr),
    .flag_q  (err_q)
  );

  uirq_rx_idle #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_count    (rx_count),
    .rx_char_stb (rx_char_stb),
    .rx_pop_stb  (rx_pop_stb),
    .limit       (rx_idle_limit),
    .clr         (clr_wr && wr_data[F_IDLE]),
    .flag_q      (idle_q)
  );

  always_comb begin
    flags                  = '0;
    flags[F_IDLE]          = idle_q;
    flags[F_ERR0 +: NERR]  = err_q;
    flags[F_TXWM]          = txwm_q;
    flags[F_TXDONE]        = txdone_q;
    flags[F_RXWM]          = rxwm_q;

    mask                   = '0;
    mask[F_IDLE]           = en_q[E_IDLE];
    mask[F_ERR0 +: NERR]   = {NERR{en_q[E_ERR]}};
    mask[F_TXWM]           = en_q[E_TXWM];
    mask[F_TXDONE]         = en_q[E_TXDONE];
    mask[F_RXWM]           = en_q[E_RXWM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else
      irq_q <= |(flags & mask);
  end

  always_comb begin
    irq     = irq_q;
    flag_o  = flags;
    rd_data = (rd_addr == SEL_FLAGS) ? flags : {{(8-NEN){1'b0}}, en_q};
  end
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker #(
  parameter int CNT_W = 5,
  parameter int TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] tx_level,
  input logic             tx_shift_busy,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] rx_level,
  input logic             err_overrun,
  input logic             err_parity,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [7:0]       wr_data,
  input logic [6:0]       en_q,
  input logic [7:0]       flag_o,
  input logic             irq,
  input logic             tx_dma_req,
  input logic             rx_dma_req
);
  logic [7:0] chk_mask;
  always_comb chk_mask = {en_q[4], en_q[3], en_q[2], {4{en_q[1]}}, en_q[0]};

  AST_TXDMA_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tx_dma_req == ($past(en_q[5]) && ($past(tx_count) < $past(tx_level)))); // R6
  AST_RXDMA_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_dma_req == ($past(en_q[6]) && ($past(rx_count) == $past(rx_level)))); // R7
  AST_TXDONE_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flag_o[6] == (($past(tx_count) == '0) && !$past(tx_shift_busy))); // R4
  AST_RXWM_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> flag_o[7] == (($past(rx_level) != '0) && ($past(rx_count) >= $past(rx_level)))); // R5
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> flag_o[2]); // R8
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o[1] && !(wr_en && wr_addr && wr_data[1]) |=> flag_o[1]); // R9
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(flag_o & chk_mask))); // R10
endmodule

bind uart_irq_dma_ctrl uirq_checker #(.CNT_W(CNT_W), .TMO_W(TMO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_count      (tx_count),
  .tx_level      (tx_level),
  .tx_shift_busy (tx_shift_busy),
  .rx_count      (rx_count),
  .rx_level      (rx_level),
  .err_overrun   (err_overrun),
  .err_parity    (err_parity),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .en_q          (en_q),
  .flag_o        (flag_o),
  .irq           (irq),
  .tx_dma_req    (tx_dma_req),
  .rx_dma_req    (rx_dma_req)
);

// File: tb/tb_uart_irq_dma_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_dma_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 5;
  localparam int TMO_W = 16;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] tx_count = '0, tx_level = '0, rx_count = '0, rx_level = '0;
  logic tx_shift_busy = 1'b0, rx_char_stb = 1'b0, rx_pop_stb = 1'b0;
  logic [TMO_W-1:0] rx_idle_limit = '0;
  logic err_overrun = 1'b0, err_parity = 1'b0, err_framing = 1'b0, err_break = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, flag_o;
  logic irq, tx_dma_req, rx_dma_req;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_dma_ctrl #(.CNT_W(CNT_W), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .tx_level(tx_level),
    .tx_shift_busy(tx_shift_busy), .rx_count(rx_count), .rx_level(rx_level),
    .rx_char_stb(rx_char_stb), .rx_pop_stb(rx_pop_stb), .rx_idle_limit(rx_idle_limit),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_framing(err_framing),
    .err_break(err_break), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag_o(flag_o), .irq(irq),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  // behavioural reference model
  int m_en, m_flags, m_idle;
  bit m_irq, m_txreq, m_rxreq;

  function automatic int mask_of(int en);
    int mk = 0;
    if (en & 1)  mk |= 8'h01;
    if (en & 2)  mk |= 8'h1E;
    if (en & 4)  mk |= 8'h20;
    if (en & 8)  mk |= 8'h40;
    if (en & 16) mk |= 8'h80;
    return mk;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_flags = 0; m_idle = 0; m_irq = 0; m_txreq = 0; m_rxreq = 0;
    end else begin
      int nf;
      bit clr;
      m_irq = (m_flags & mask_of(m_en)) != 0;
      nf = m_flags & 8'h1F;
      if (int'(tx_count) < int'(tx_level)) nf |= 8'h20;
      if (tx_count == 0 && !tx_shift_busy) nf |= 8'h40;
      if (rx_level != 0 && int'(rx_count) >= int'(rx_level)) nf |= 8'h80;
      clr = wr_en && wr_addr;
      if (clr) nf &= ~(int'(wr_data) & 8'h1F);
      if (err_overrun) nf |= 8'h02;
      if (err_parity)  nf |= 8'h04;
      if (err_framing) nf |= 8'h08;
      if (err_break)   nf |= 8'h10;
      if (rx_count == 0 || rx_char_stb || rx_pop_stb) m_idle = 0;
      else if (m_idle < int'(rx_idle_limit)) begin
        m_idle++;
        if (m_idle == int'(rx_idle_limit)) nf |= 8'h01;
      end
      m_txreq = ((m_en >> 5) & 1) != 0 && int'(tx_count) < int'(tx_level);
      m_rxreq = ((m_en >> 6) & 1) != 0 && rx_count == rx_level;
      if (wr_en && !wr_addr) m_en = int'(wr_data) & 8'h7F;
      m_flags = nf;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string bit_tag(int i);
    if (i == 0) return "R11";
    if (i <= 4) return "R8";
    if (i == 5) return "R3";
    if (i == 6) return "R4";
    return "R5";
  endfunction

  task automatic cmp_all();
    for (int i = 0; i < 8; i++)
      chk($sformatf("%s flag bit %0d", bit_tag(i), i), int'(flag_o[i]), (m_flags >> i) & 1);
    chk("R6 tx_dma_req", int'(tx_dma_req), int'(m_txreq));
    chk("R7 rx_dma_req", int'(rx_dma_req), int'(m_rxreq));
    chk("R10 irq", int'(irq), int'(m_irq));
    chk("R2 rd_data", int'(rd_data), rd_addr ? m_flags : m_en);
  endtask

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic wr(input bit a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tx_count = 5'd8;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 flags at reset", int'(flag_o), 0);
    chk("R1 irq at reset", int'(irq), 0);
    chk("R1 dma at reset", int'({tx_dma_req, rx_dma_req}), 0);
    chk("R1 enables at reset", int'(rd_data), 0);
    rst_n = 1'b1;
    step(2);

    // R12 enables, R2 readback
    wr(1'b0, 8'hFF);
    chk("R12 enable load drops bit7", int'(rd_data), 8'h7F);
    rd_addr = 1'b1;
    step();
    chk("R2 rd flags equals flag_o", int'(rd_data), int'(flag_o));

    // R3/R6 transmit watermark around level 4
    tx_level = 5'd4;
    tx_count = 5'd3; step();
    chk("R3 txwm at level-1", int'(flag_o[5]), 1);
    chk("R6 txreq at level-1", int'(tx_dma_req), 1);
    tx_count = 5'd4; step();
    chk("R3 txwm at level", int'(flag_o[5]), 0);
    chk("R6 txreq at level", int'(tx_dma_req), 0);
    tx_count = 5'd5; step();
    chk("R6 txreq at level+1", int'(tx_dma_req), 0);

    // R5/R7 receive watermark around level 6
    rx_level = 5'd6;
    rx_count = 5'd5; step();
    chk("R5 rxwm at level-1", int'(flag_o[7]), 0);
    chk("R7 rxreq at level-1", int'(rx_dma_req), 0);
    rx_count = 5'd6; step();
    chk("R5 rxwm at level", int'(flag_o[7]), 1);
    chk("R7 rxreq at level", int'(rx_dma_req), 1);
    rx_count = 5'd7; step();
    chk("R5 rxwm at level+1", int'(flag_o[7]), 1);
    chk("R7 rxreq at level+1", int'(rx_dma_req), 0);

    // R6/R7 DMA enables off
    wr(1'b0, 8'h1F);
    tx_count = 5'd1; rx_count = 5'd6; step(2);
    chk("R6 txreq without enable", int'(tx_dma_req), 0);
    chk("R7 rxreq without enable", int'(rx_dma_req), 0);

    // R4 transmit complete
    tx_count = 5'd0; tx_shift_busy = 1'b1; step();
    chk("R4 txdone while shifting", int'(flag_o[6]), 0);
    tx_shift_busy = 1'b0; step();
    chk("R4 txdone when idle", int'(flag_o[6]), 1);
    tx_count = 5'd1; step();
    chk("R4 txdone with fifo entry", int'(flag_o[6]), 0);

    // R8/R9 sticky errors and write-one-to-clear
    err_parity = 1'b1; step(); err_parity = 1'b0;
    step(3);
    chk("R8 parity sticky", int'(flag_o[2]), 1);
    err_break = 1'b1; step(); err_break = 1'b0;
    wr(1'b1, 8'h04);
    chk("R9 parity cleared", int'(flag_o[2]), 0);
    chk("R9 break untouched", int'(flag_o[4]), 1);
    err_overrun = 1'b1; wr(1'b1, 8'h02); err_overrun = 1'b0;
    chk("R9 set wins over clear", int'(flag_o[1]), 1);
    tx_count = 5'd0; step();
    wr(1'b1, 8'hE0);
    chk("R9 level flags ignore clear", int'(flag_o[7:5]), 3'b111);
    wr(1'b1, 8'h1F);
    chk("R9 all sticky cleared", int'(flag_o[4:0]), 0);

    // R11 idle timeout, limit 5
    rx_count = 5'd2; rx_idle_limit = 16'd5; rx_char_stb = 1'b1; step(); rx_char_stb = 1'b0;
    step(4);
    chk("R11 no timeout at 4 edges", int'(flag_o[0]), 0);
    step();
    chk("R11 timeout at 5 edges", int'(flag_o[0]), 1);
    wr(1'b1, 8'h01);
    chk("R11 timeout cleared", int'(flag_o[0]), 0);
    rx_pop_stb = 1'b1; step(); rx_pop_stb = 1'b0;
    step(2);
    rx_char_stb = 1'b1; step(); rx_char_stb = 1'b0;
    step(4);
    chk("R11 restart by char", int'(flag_o[0]), 0);
    step();
    chk("R11 timeout after restart", int'(flag_o[0]), 1);
    wr(1'b1, 8'h01);
    rx_count = 5'd0; step(10);
    chk("R11 empty fifo no timeout", int'(flag_o[0]), 0);
    rx_count = 5'd3; rx_idle_limit = 16'd0; step(10);
    chk("R11 limit zero disables", int'(flag_o[0]), 0);

    // R10 interrupt masking
    wr(1'b0, 8'h00); step();
    chk("R10 irq off with no enables", int'(irq), 0);
    tx_count = 5'd0; tx_shift_busy = 1'b0;
    wr(1'b0, 8'h08); step();
    chk("R10 irq from txdone", int'(irq), 1);
    tx_shift_busy = 1'b1; step(2);
    chk("R10 irq follows flag drop", int'(irq), 0);
    err_framing = 1'b1; step(); err_framing = 1'b0;
    wr(1'b0, 8'h02); step();
    chk("R10 irq from line status", int'(irq), 1);

    // reset again mid-run
    rst_n = 1'b0; @(negedge clk);
    chk("R1 flags after second reset", int'(flag_o), 0);
    rst_n = 1'b1; step(3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule